// File: doc/BRIEF.md
# Structured Branch Unit with Return Stack

This block owns the program counter for structured control flow. Each cycle it takes an operation code and the zero flag. It also takes the operands that the decoder has already extracted: two label offsets, the offset of the instruction itself, and two candidate block-start offsets. From these it resolves a while loop, an if, an if-else or an end-of-block marker. Every operation completes in a single clock cycle.

Loops and if-else constructs do not use explicit backward or forward jumps. They rely on a small internal return stack. Entering a while body pushes the offset of the while instruction, so the condition is evaluated again later. Entering the taken arm of an if-else pushes the offset that follows the else block. A null terminator at the end of a block pops the stack into the program counter. Pushing onto a full stack and popping an empty stack are both reported as one-cycle error pulses, and neither changes any state.

Top module: `branch_stack_unit`

## Requirements
- R1: After reset, pc is 0, depth is 0, stk_empty is 1, stk_full is 0, and overflow and underflow are 0.
- R2: For op codes 1 (while), 2 (if) and 3 (if-else), a set zero_flag means the decision is false. pc becomes label0 on the next edge and depth does not change.
- R3: For op 1 with zero_flag clear, on the same edge instr_ofs is pushed, pc becomes blk_start and depth rises by one.
- R4: For op 2 with zero_flag clear, pc becomes blk_start and the stack is untouched.
- R5: For op 3 with zero_flag clear, on the same edge label1 is pushed, pc becomes ie_start and depth rises by one.
- R6: For op 4 (null terminator) with a non-empty stack, the most recently pushed offset is loaded into pc and depth falls by one. Values come back in last-in, first-out order.
- R7: A push request (op 1 or 3 with zero_flag clear) while depth equals DEPTH (8) raises overflow for exactly one cycle. pc, depth and the stack contents stay unchanged.
- R8: Op 4 with an empty stack raises underflow for exactly one cycle. pc and depth stay unchanged.
- R9: Op codes 0, 5, 6 and 7 are idle: pc and depth hold, and overflow and underflow read 0 on the following cycle.
- R10: stk_full is 1 exactly when depth equals DEPTH, and stk_empty is 1 exactly when depth is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op | input | 3 | 0 idle, 1 while, 2 if, 3 if-else, 4 null terminator, 5-7 idle |
| zero_flag | input | 1 | Set means the condition is false |
| label0 | input | 8 | Skip target, or else-block start for if-else |
| label1 | input | 8 | Offset after the else block (if-else only) |
| instr_ofs | input | 8 | Offset of the current while instruction |
| blk_start | input | 8 | First instruction of a while or if body |
| ie_start | input | 8 | First instruction of the if arm of an if-else |
| pc | output | 8 | Program counter |
| depth | output | 4 | Number of stack entries in use |
| stk_full | output | 1 | Stack holds DEPTH entries |
| stk_empty | output | 1 | Stack holds no entries |
| overflow | output | 1 | One-cycle pulse on a rejected push |
| underflow | output | 1 | One-cycle pulse on a rejected pop |

## Verification
The assertions assume that op, zero_flag and the offset inputs are stable around each rising edge and are known whenever reset is released. They also assume that reset is applied long enough to clear the pointer. The stimulus changes inputs only on falling edges and holds reset over several edges. It then sweeps every op code against both flag values over many rounds, with operands derived from the round and op indices, so the stack repeatedly crosses its full and empty limits. Explicit fill-to-overflow and drain-to-underflow passes then confirm last-in, first-out order at the boundaries.

// File: rtl/branch_stack_unit.sv
module branch_stack_unit #(
  parameter int OFS_W = 8,
  parameter int DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [2:0]                    op,
  input  logic                          zero_flag,
  input  logic [OFS_W-1:0]              label0,
  input  logic [OFS_W-1:0]              label1,
  input  logic [OFS_W-1:0]              instr_ofs,
  input  logic [OFS_W-1:0]              blk_start,
  input  logic [OFS_W-1:0]              ie_start,
  output logic [OFS_W-1:0]              pc,
  output logic [$clog2(DEPTH+1)-1:0]    depth,
  output logic                          stk_full,
  output logic                          stk_empty,
  output logic                          overflow,
  output logic                          underflow
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  localparam logic [2:0] OP_WHILE  = 3'd1;
  localparam logic [2:0] OP_IF     = 3'd2;
  localparam logic [2:0] OP_IFELSE = 3'd3;
  localparam logic [2:0] OP_NULL   = 3'd4;

  logic [OFS_W-1:0] stk [DEPTH];
  logic [CNT_W-1:0] cnt;

  wire is_br    = (op == OP_WHILE) || (op == OP_IF) || (op == OP_IFELSE);
  wire taken    = is_br && !zero_flag;
  wire push_req = taken && (op != OP_IF);
  wire pop_req  = (op == OP_NULL);

  assign stk_full  = (cnt == CNT_W'(DEPTH));
  assign stk_empty = (cnt == '0);
  assign depth     = cnt;

  wire push_ok = push_req && !stk_full;
  wire pop_ok  = pop_req && !stk_empty;
  wire ovf     = push_req && stk_full;
  wire unf     = pop_req && stk_empty;

  wire [OFS_W-1:0] push_val = (op == OP_WHILE) ? instr_ofs : label1;
  wire [OFS_W-1:0] target   = (op == OP_IFELSE) ? ie_start : blk_start;
  wire [IDX_W-1:0] wr_idx   = IDX_W'(cnt);
  wire [IDX_W-1:0] top_idx  = IDX_W'(cnt - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc        <= '0;
      cnt       <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= ovf;
      underflow <= unf;
      if (is_br && zero_flag)
        pc <= label0;
      else if (taken && !ovf)
        pc <= target;
      else if (pop_ok)
        pc <= stk[top_idx];
      if (push_ok)
        cnt <= cnt + 1'b1;
      else if (pop_ok)
        cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && push_ok)
      stk[wr_idx] <= push_val;
  end
endmodule

// File: rtl/branch_stack_unit_chk.sv
module branch_stack_unit_chk #(
  parameter int OFS_W = 8,
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [2:0]                 op,
  input logic                       zero_flag,
  input logic [OFS_W-1:0]           label0,
  input logic [OFS_W-1:0]           blk_start,
  input logic [OFS_W-1:0]           ie_start,
  input logic [OFS_W-1:0]           pc,
  input logic [$clog2(DEPTH+1)-1:0] depth,
  input logic                       stk_full,
  input logic                       stk_empty,
  input logic                       overflow,
  input logic                       underflow
);
  AST_FALSE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == 3'd1 || op == 3'd2 || op == 3'd3) && zero_flag) |=> (pc == $past(label0)) && $stable(depth)); // R2
  AST_WHILE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd1 && !zero_flag && !stk_full) |=> (pc == $past(blk_start)) && (depth == $past(depth) + 1'b1)); // R3
  AST_IF_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd2 && !zero_flag) |=> (pc == $past(blk_start)) && $stable(depth)); // R4
  AST_IFELSE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd3 && !zero_flag && !stk_full) |=> (pc == $past(ie_start)) && (depth == $past(depth) + 1'b1)); // R5
  AST_POP_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd4 && !stk_empty) |=> (depth == $past(depth) - 1'b1)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == 3'd1 || op == 3'd3) && !zero_flag && stk_full) |=> overflow && $stable(pc) && $stable(depth)); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd4 && stk_empty) |=> underflow && $stable(pc) && $stable(depth)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd0 || op > 3'd4) |=> $stable(pc) && $stable(depth) && !overflow && !underflow); // R9
  AST_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_full == (depth == DEPTH)) && (stk_empty == (depth == 0)) && (depth <= DEPTH)); // R10
endmodule

bind branch_stack_unit branch_stack_unit_chk #(.OFS_W(OFS_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .zero_flag(zero_flag), .label0(label0),
  .blk_start(blk_start), .ie_start(ie_start), .pc(pc), .depth(depth),
  .stk_full(stk_full), .stk_empty(stk_empty), .overflow(overflow), .underflow(underflow)
);

// File: tb/tb_branch_stack_unit.sv
module tb_branch_stack_unit;
  localparam int D = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] op = '0;
  logic zero_flag = 1'b0;
  logic [7:0] label0 = '0, label1 = '0, instr_ofs = '0, blk_start = '0, ie_start = '0;
  logic [7:0] pc;
  logic [3:0] depth;
  logic stk_full, stk_empty, overflow, underflow;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] m_stk [D];
  int m_cnt = 0;
  logic [7:0] m_pc = '0;
  bit m_ovf = 0, m_unf = 0;

  always #2.5 clk = ~clk;

  branch_stack_unit dut (
    .clk(clk), .rst_n(rst_n), .op(op), .zero_flag(zero_flag), .label0(label0),
    .label1(label1), .instr_ofs(instr_ofs), .blk_start(blk_start), .ie_start(ie_start),
    .pc(pc), .depth(depth), .stk_full(stk_full), .stk_empty(stk_empty),
    .overflow(overflow), .underflow(underflow)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "pc", int'(pc), int'(m_pc));
    check(req, "depth", int'(depth), m_cnt);
    check(req, "overflow", int'(overflow), int'(m_ovf));
    check(req, "underflow", int'(underflow), int'(m_unf));
    check("R10", "stk_full", int'(stk_full), int'(m_cnt == D));
    check("R10", "stk_empty", int'(stk_empty), int'(m_cnt == 0));
  endtask

  task automatic step(input logic [2:0] o, input bit z, input logic [7:0] l0, input logic [7:0] l1,
                      input logic [7:0] io, input logic [7:0] bs, input logic [7:0] ies);
    string req;
    @(negedge clk);
    op = o; zero_flag = z; label0 = l0; label1 = l1; instr_ofs = io; blk_start = bs; ie_start = ies;
    m_ovf = 0; m_unf = 0;
    if (o >= 3'd1 && o <= 3'd3 && z) begin
      req = "R2"; m_pc = l0;
    end else if (o == 3'd1 || o == 3'd3) begin
      if (m_cnt == D) begin
        req = "R7"; m_ovf = 1;
      end else begin
        req = (o == 3'd1) ? "R3" : "R5";
        m_stk[m_cnt] = (o == 3'd1) ? io : l1;
        m_cnt++;
        m_pc = (o == 3'd1) ? bs : ies;
      end
    end else if (o == 3'd2) begin
      req = "R4"; m_pc = bs;
    end else if (o == 3'd4) begin
      if (m_cnt == 0) begin
        req = "R8"; m_unf = 1;
      end else begin
        req = "R6"; m_cnt--; m_pc = m_stk[m_cnt];
      end
    end else begin
      req = "R9";
    end
    @(posedge clk);
    #1;
    check_all(req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < 60; r++) begin
      for (int o = 0; o < 8; o++) begin
        for (int z = 0; z < 2; z++) begin
          step(3'(o), z[0], 8'(r*7 + o), 8'(r*11 + 3*o + 1), 8'(r*13 + o + z),
               8'(r*5 + 17*o + 2), 8'(r*3 + 29*o + 9));
        end
        if (r % 3 == 0) step(3'd4, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
      end
    end
    while (m_cnt > 0) step(3'd4, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    step(3'd4, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    for (int i = 0; i < D + 1; i++)
      step(i[0] ? 3'd3 : 3'd1, 1'b0, 8'hF0, 8'(100 + i), 8'(40 + i), 8'(i + 1), 8'(200 + i));
    step(3'd1, 1'b0, 8'hF0, 8'h00, 8'h77, 8'h66, 8'h55);
    step(3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    for (int i = 0; i < D + 2; i++)
      step(3'd4, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    step(3'd7, 1'b1, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'hEE);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule